// File: doc/BRIEF.md
# Ternary Loop Settling Checker

This block decides whether a small gate network with a feedback loop settles to definite logic values for every input assignment. The network is a ring of six two-input gates. Each gate takes one of three primary inputs and the output of the gate before it. The first gate takes its second operand from the last gate's output, which closes the ring. Gates alternate between AND and OR, starting with AND. Signals carry three values: 0, 1 and unknown. The loop is cut where the last gate feeds the first, and that cut point starts at unknown.

After a start pulse, the engine visits all eight input vectors in ascending order. For each vector it evaluates the opened ring once per clock. It then loads the cut point with the value the last gate produced. When the cut point keeps its value from one iteration to the next, the vector has reached its fixed point. The vector passes when all six gate outputs are definite at that point.

The engine builds an eight-bit pass mask and an overall verdict. It keeps the settled gate values of the most recent vector, and it raises sticky flags for two errors: an iteration bound that is exceeded, and a cut value that changes after it has become definite. A parameter selects which ring positions are OR gates, so the same engine can judge a variant ring.

Top module: `ternary_loop_checker`

## Requirements
- R1: After reset, busy, done, verdict, pass_mask, out_val, out_known, mono_err and bound_err are all 0.
- R2: A start pulse seen while idle begins a sweep. busy is 1 from the next cycle until the sweep ends, and pass_mask and verdict are cleared in that same edge. A start pulse that arrives while busy has no effect on the sweep or its results.
- R3: Each signal is two rails (lo, hi). lo=1 means 0, hi=1 means 1, and neither rail set means unknown. A primary input bit b gives lo=~b and hi=b. An AND gate sets lo when either input's lo is set, and sets hi only when both inputs' hi are set. An OR gate is the dual of this. No node ever has both rails set.
- R4: Gate g (g=0..5) combines input bit x[g mod 3] with the output of gate g-1. Gate 0 uses the cut value instead. Gate g is an OR when bit g of OR_MASK is 1 (default 6'b101010) and an AND otherwise. The cut starts at unknown for every vector, and every busy cycle loads it with gate 5's output.
- R5: A vector finishes in the cycle in which gate 5's output equals the current cut value. With the default ring, every vector takes exactly two iteration cycles. done is a one-cycle pulse, high in the cycle after the 16th clock edge that follows the accepting edge.
- R6: The input vector is v, with x1=v[0], x2=v[1] and x3=v[2]. pass_mask[v] is set when all six outputs are definite at v's fixed point.
- R7: verdict is updated together with done and equals 1 exactly when all eight pass_mask bits are 1.
- R8: When a vector finishes, out_val and out_known (bit g for gate g) take its settled values. With the default ring these are x1(x2+x3), x2+x1x3, x3(x1+x2), x1+x2x3, x2(x1+x3) and x3+x1x2 for gates 0 to 5, all known.
- R9: A vector that reaches ITER_BOUND iterations (default 4) without settling fails and sets bound_err. With the default ring bound_err stays 0.
- R10: mono_err is set if a cut value that is already definite is loaded with a different value. It stays 0 for a monotone ring.
- R11: With OR_MASK=0 (all AND), vector 7 stays unknown after one iteration and fails. The sweep gives pass_mask=8'h7F, verdict=0 and out_known=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a sweep when idle |
| busy | output | 1 | Sweep in progress |
| done | output | 1 | One-cycle pulse at sweep end |
| pass_mask | output | 8 | Per-vector settled flag |
| verdict | output | 1 | All vectors settled |
| out_val | output | 6 | Settled value of each gate (last vector) |
| out_known | output | 6 | Definite flag of each gate (last vector) |
| mono_err | output | 1 | Cut value changed after becoming definite |
| bound_err | output | 1 | Iteration bound reached without settling |

## Verification
The bench compares every cycle against a behavioural three-valued model. A design that seeded the cut with 0 or 1 instead of unknown would still pass the default ring, but it would wrongly clear vector 7 of the all-AND ring. A design that stopped one iteration early or late would shift done and the out_val updates, and the bench samples exactly at those updates. It also checks each settled vector against the closed-form formulas, and it issues a start pulse mid-sweep, which a design that restarted on that pulse would show as a lost mask and a late done.

// File: rtl/tern_loop_pkg.sv
package tern_loop_pkg;

  // lo set: value is 0, hi set: value is 1, neither: unknown
  typedef struct packed {
    logic lo;
    logic hi;
  } tern_t;

  localparam tern_t T_UNK = '{lo: 1'b0, hi: 1'b0};

  function automatic tern_t t_of_bit(input logic b);
    tern_t r;
    r.lo = ~b;
    r.hi = b;
    return r;
  endfunction

  function automatic tern_t t_and(input tern_t a, input tern_t b);
    tern_t r;
    r.lo = a.lo | b.lo;
    r.hi = a.hi & b.hi;
    return r;
  endfunction

  function automatic tern_t t_or(input tern_t a, input tern_t b);
    tern_t r;
    r.lo = a.lo & b.lo;
    r.hi = a.hi | b.hi;
    return r;
  endfunction

  function automatic logic t_known(input tern_t a);
    return a.lo | a.hi;
  endfunction

endpackage

// File: rtl/tern_ring.sv
module tern_ring import tern_loop_pkg::*; #(
  parameter int N_IN = 3,
  parameter int N_GATE = 6,
  parameter logic [N_GATE-1:0] OR_MASK = 6'b101010
) (
  input  logic [N_IN-1:0]   x,
  input  tern_t             cut_in,
  output tern_t [N_GATE-1:0] node
);

  tern_t [N_GATE-1:0] feed;

  assign feed[0] = cut_in;

  for (genvar g = 0; g < N_GATE; g++) begin : g_gate
    if (g > 0) begin : g_chain
      assign feed[g] = node[g-1];
    end
    if (OR_MASK[g]) begin : g_or
      assign node[g] = t_or(t_of_bit(x[g % N_IN]), feed[g]);
    end else begin : g_and
      assign node[g] = t_and(t_of_bit(x[g % N_IN]), feed[g]);
    end
  end

endmodule

// File: rtl/tern_cut_reg.sv
module tern_cut_reg import tern_loop_pkg::*; (
  input  logic  clk,
  input  logic  rst_n,
  input  logic  clr_unk,
  input  logic  adv,
  input  logic  err_clr,
  input  tern_t nxt,
  output tern_t cut,
  output logic  mono_err
);

  logic shrink_bad;

  assign shrink_bad = adv & ~clr_unk & t_known(cut) & (nxt != cut);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cut      <= T_UNK;
      mono_err <= 1'b0;
    end else begin
      if (clr_unk)      cut <= T_UNK;
      else if (adv)     cut <= nxt;
      if (err_clr)         mono_err <= 1'b0;
      else if (shrink_bad) mono_err <= 1'b1;
    end
  end

  // R10: a definite cut value is never replaced by another value
  p_cut_monotone_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (adv && !clr_unk && t_known(cut)) |=> (cut == $past(cut)));

  // R4: a vector restart leaves the cut unknown
  p_cut_seed_unknown_r4: assert property (@(posedge clk) disable iff (!rst_n)
    clr_unk |=> !t_known(cut));

endmodule

// File: rtl/tern_sweep_ctrl.sv
module tern_sweep_ctrl #(
  parameter int N_SEL = 3,
  parameter int ITER_BOUND = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             changed,
  output logic             busy,
  output logic [N_SEL-1:0] vec,
  output logic             accept,
  output logic             fin,
  output logic             last,
  output logic             bound_hit
);

  localparam int IW = $clog2(ITER_BOUND + 1);

  logic [IW-1:0] iter;
  logic [IW-1:0] iter_nx;
  logic          cap;

  assign iter_nx   = iter + 1'b1;
  assign cap       = (iter_nx >= IW'(ITER_BOUND));
  assign accept    = ~busy & start;
  assign fin       = busy & (~changed | cap);
  assign bound_hit = busy & changed & cap;
  assign last      = (vec == {N_SEL{1'b1}});

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy <= 1'b0;
      vec  <= '0;
      iter <= '0;
    end else if (accept) begin
      busy <= 1'b1;
      vec  <= '0;
      iter <= '0;
    end else if (busy) begin
      if (fin) begin
        iter <= '0;
        if (last) busy <= 1'b0;
        else      vec  <= vec + 1'b1;
      end else begin
        iter <= iter_nx;
      end
    end
  end

  // R9: the iteration count stays under the bound
  p_iter_cap_r9: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (iter < IW'(ITER_BOUND)));

  // R2: an accepted start makes the engine busy
  p_busy_after_start_r2: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> busy);

  // R2: mid-vector, nothing (including start) moves the vector index
  p_vec_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !fin) |=> (busy && vec == $past(vec)));

endmodule

// File: rtl/ternary_loop_checker.sv
module ternary_loop_checker import tern_loop_pkg::*; #(
  parameter int N_IN = 3,
  parameter int N_GATE = 6,
  parameter logic [N_GATE-1:0] OR_MASK = 6'b101010,
  parameter int ITER_BOUND = 4
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   start,
  output logic                   busy,
  output logic                   done,
  output logic [(1<<N_IN)-1:0]   pass_mask,
  output logic                   verdict,
  output logic [N_GATE-1:0]      out_val,
  output logic [N_GATE-1:0]      out_known,
  output logic                   mono_err,
  output logic                   bound_err
);

  localparam int N_VEC = 1 << N_IN;

  logic [N_IN-1:0]    vec;
  logic               accept, fin, last, bound_hit, changed;
  tern_t              cut;
  tern_t [N_GATE-1:0] node;
  logic [N_GATE-1:0]  node_val, node_known, node_clash;
  logic               pass_now, rail_clash;
  logic [N_VEC-1:0]   mask_after;

  tern_sweep_ctrl #(.N_SEL(N_IN), .ITER_BOUND(ITER_BOUND)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .start(start), .changed(changed),
    .busy(busy), .vec(vec), .accept(accept), .fin(fin), .last(last),
    .bound_hit(bound_hit)
  );

  tern_ring #(.N_IN(N_IN), .N_GATE(N_GATE), .OR_MASK(OR_MASK)) u_ring (
    .x(vec), .cut_in(cut), .node(node)
  );

  tern_cut_reg u_cut (
    .clk(clk), .rst_n(rst_n),
    .clr_unk(accept | (fin & ~last)),
    .adv(busy), .err_clr(accept),
    .nxt(node[N_GATE-1]), .cut(cut), .mono_err(mono_err)
  );

  for (genvar g = 0; g < N_GATE; g++) begin : g_flat
    assign node_val[g]   = node[g].hi;
    assign node_known[g] = t_known(node[g]);
    assign node_clash[g] = node[g].lo & node[g].hi;
  end

  assign changed    = (node[N_GATE-1] != cut);
  assign rail_clash = |node_clash;
  assign pass_now   = (&node_known) & ~bound_hit;
  assign mask_after = pass_mask | (N_VEC'(pass_now) << vec);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      done      <= 1'b0;
      pass_mask <= '0;
      verdict   <= 1'b0;
      out_val   <= '0;
      out_known <= '0;
      bound_err <= 1'b0;
    end else begin
      done <= 1'b0;
      if (accept) begin
        pass_mask <= '0;
        verdict   <= 1'b0;
        bound_err <= 1'b0;
      end else if (fin) begin
        pass_mask <= mask_after;
        out_val   <= node_val;
        out_known <= node_known;
        if (bound_hit) bound_err <= 1'b1;
        if (last) begin
          done    <= 1'b1;
          verdict <= &mask_after;
        end
      end
    end
  end

  // R3: no ring node ever claims both 0 and 1
  p_rails_legal_r3: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !rail_clash);

  // R5: done lasts exactly one cycle
  p_done_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R7: verdict agrees with the completed mask
  p_verdict_mask_r7: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (verdict == &pass_mask));

  // R6: a settled vector's mask bit reflects definiteness of all outputs
  p_pass_known_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (fin && !bound_hit) |=> (pass_mask[$past(vec)] == &out_known));

endmodule

// File: tb/ternary_loop_checker_tb.sv
module tern_loop_model #(
  parameter logic [5:0] OR_MASK = 6'b101010
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start,
  output logic       busy,
  output logic       done,
  output logic [7:0] mask,
  output logic       verdict,
  output logic [5:0] val,
  output logic [5:0] known
);
  // values: 0, 1, 2 = unknown
  int y, vec, iter;

  function automatic int m_and(int a, int b);
    if (a == 0 || b == 0) return 0;
    if (a == 1 && b == 1) return 1;
    return 2;
  endfunction

  function automatic int m_or(int a, int b);
    if (a == 1 || b == 1) return 1;
    if (a == 0 && b == 0) return 0;
    return 2;
  endfunction

  always @(posedge clk) begin
    int g [6];
    int prev;
    int xi;
    bit ok;
    logic [7:0] mnew;
    if (!rst_n) begin
      busy <= 0; done <= 0; mask <= 0; verdict <= 0; val <= 0; known <= 0;
      y = 2; vec = 0; iter = 0;
    end else begin
      done <= 0;
      if (!busy) begin
        if (start) begin
          busy <= 1; mask <= 0; verdict <= 0;
          vec = 0; y = 2; iter = 0;
        end
      end else begin
        prev = y;
        for (int i = 0; i < 6; i++) begin
          xi = (vec >> (i % 3)) & 1;
          g[i] = OR_MASK[i] ? m_or(xi, prev) : m_and(xi, prev);
          prev = g[i];
        end
        iter = iter + 1;
        if (g[5] == y || iter >= 4) begin
          ok = (g[5] == y);
          for (int i = 0; i < 6; i++) begin
            known[i] <= (g[i] != 2);
            val[i]   <= (g[i] == 1);
            if (g[i] == 2) ok = 0;
          end
          mnew = mask;
          mnew[vec] = ok;
          mask <= mnew;
          if (vec == 7) begin
            busy <= 0; done <= 1; verdict <= &mnew;
          end else begin
            vec = vec + 1; y = 2; iter = 0;
          end
        end else begin
          y = g[5];
        end
      end
    end
  end
endmodule

module ternary_loop_checker_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  int total = 0;
  int bad = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  logic       busy, done, verdict, mono_err, bound_err;
  logic [7:0] pass_mask;
  logic [5:0] out_val, out_known;
  logic       a_busy, a_done, a_verdict, a_mono, a_bound;
  logic [7:0] a_mask;
  logic [5:0] a_val, a_known;
  logic       e_busy, e_done, e_verdict, f_busy, f_done, f_verdict;
  logic [7:0] e_mask, f_mask;
  logic [5:0] e_val, e_known, f_val, f_known;

  ternary_loop_checker u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .done(done),
    .pass_mask(pass_mask), .verdict(verdict), .out_val(out_val),
    .out_known(out_known), .mono_err(mono_err), .bound_err(bound_err)
  );

  ternary_loop_checker #(.OR_MASK(6'b000000)) u_dut_and (
    .clk(clk), .rst_n(rst_n), .start(start), .busy(a_busy), .done(a_done),
    .pass_mask(a_mask), .verdict(a_verdict), .out_val(a_val),
    .out_known(a_known), .mono_err(a_mono), .bound_err(a_bound)
  );

  tern_loop_model #(.OR_MASK(6'b101010)) u_ref (
    .clk(clk), .rst_n(rst_n), .start(start), .busy(e_busy), .done(e_done),
    .mask(e_mask), .verdict(e_verdict), .val(e_val), .known(e_known)
  );

  tern_loop_model #(.OR_MASK(6'b000000)) u_ref_and (
    .clk(clk), .rst_n(rst_n), .start(start), .busy(f_busy), .done(f_done),
    .mask(f_mask), .verdict(f_verdict), .val(f_val), .known(f_known)
  );

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [5:0] formula(input int v);
    logic x1, x2, x3;
    x1 = v[0]; x2 = v[1]; x3 = v[2];
    return {x3 | (x1 & x2), x2 & (x1 | x3), x1 | (x2 & x3),
            x3 & (x1 | x2), x2 | (x1 & x3), x1 & (x2 | x3)};
  endfunction

  // R4 R5: per-cycle comparison with the behavioural model
  always @(negedge clk) begin
    logic [23:0] act, exp;
    if (rst_n && !finished) begin
      act = {busy, done, verdict, pass_mask, out_val, out_known, mono_err, bound_err};
      exp = {e_busy, e_done, e_verdict, e_mask, e_val, e_known, 1'b0, 1'b0};
      check(act == exp, "R4 model cycle compare (default ring)", act, exp);
      act = {a_busy, a_done, a_verdict, a_mask, a_val, a_known, a_mono, a_bound};
      exp = {f_busy, f_done, f_verdict, f_mask, f_val, f_known, 1'b0, 1'b0};
      check(act == exp, "R11 model cycle compare (and ring)", act, exp);
    end
  end

  task automatic sweep_default(input bit poke_mid);
    @(negedge clk); start = 1'b1;
    @(posedge clk);
    @(negedge clk); start = 1'b0;
    check(busy == 1'b1, "R2 busy after start", busy, 1);
    check(pass_mask == 8'h00, "R2 mask cleared at start", pass_mask, 0);
    for (int v = 0; v < 8; v++) begin
      repeat (2) @(posedge clk);
      @(negedge clk);
      start = 1'b0;
      check(out_val == formula(v) && out_known == 6'h3f, "R8 R3 settled formula",
            {out_known, out_val}, {6'h3f, formula(v)});
      check(done == (v == 7), "R5 done timing", done, (v == 7));
      if (poke_mid && v == 3) start = 1'b1;
    end
    check(pass_mask == 8'hff, "R6 pass mask", pass_mask, 8'hff);
    check(verdict == 1'b1, "R7 verdict", verdict, 1);
    @(negedge clk);
    check(done == 1'b0 && busy == 1'b0, "R5 done one cycle", {done, busy}, 0);
    check(bound_err == 1'b0, "R9 no bound error", bound_err, 0);
    check(mono_err == 1'b0, "R10 no monotonicity error", mono_err, 0);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    check({busy, done, verdict, pass_mask, out_val, out_known, mono_err, bound_err} == 0,
          "R1 reset state",
          {busy, done, verdict, pass_mask, out_val, out_known, mono_err, bound_err}, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    check(busy == 1'b0, "R2 idle without start", busy, 0);
    sweep_default(1'b1);
    check(a_mask == 8'h7f, "R11 and-ring mask", a_mask, 8'h7f);
    check(a_verdict == 1'b0, "R11 and-ring verdict", a_verdict, 0);
    check(a_known == 6'h00, "R11 and-ring vector 7 unknown", a_known, 0);
    sweep_default(1'b0);
    check(a_mask == 8'h7f && a_busy == 1'b0, "R11 repeat sweep", a_mask, 8'h7f);
    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(4 * 200000);
    finished = 1;
    bad++;
    total++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule